// File: doc/BRIEF.md
# Committed Store Drain Queue

This block holds store micro-operations in program order and hands them to a data cache port once they have left the reorder buffer. The front end allocates a slot for each new store (address and tag) and gets back the slot index it was given. Later the reorder buffer marks that slot as committed through a slot-indexed strobe. Each cycle the queue shows the cache the addresses of its oldest entries, one lane per possible issue. The cache answers with a per-lane accept bit, and a per-cycle issue budget sets the most stores that may leave.

Draining is strictly in order. The queue issues the longest run of entries, starting at the head, that are live, committed and accepted, and that run is cut off at the budget. The first uncommitted or refused entry stops draining for that cycle, and no younger store passes it. Issued entries leave the queue at the clock edge. Each issued store carries a timestamp taken from a cycle counter. A pending counter follows the stores that have been issued but whose completion the cache has not yet reported.

Top module: `store_drain_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_slot` is 0, no lane issues, and `pend_count` is 0.
- R2: Allocation fills slots 0,1,2,... in ring order (`alloc_slot` shows the slot that the next allocation takes). While all DEPTH slots are occupied, `alloc_ready` is 0 and an allocation attempt is dropped.
- R3: A store that has not been committed never issues, and no store younger than it issues in the same cycle. A commit strobe aimed at an unoccupied slot has no effect, so a store later allocated there stays uncommitted.
- R4: When the cache refuses lane k (`cache_ok[k]`=0), lane k and every younger lane do not issue in that cycle.
- R5: The number of issued lanes never exceeds `issue_budget`. A budget of 0 issues nothing.
- R6: Issue lanes form a run from lane 0 upward. Lane k carries the k-th oldest queued store's address (`probe_addr[k]`) and tag (`iss_tag[k]`).
- R7: `iss_stamp` equals the number of rising clock edges since reset was released.
- R8: `pend_count` rises by the number of stores issued in a cycle and falls by one for each `done_valid`. A completion that arrives while the count is 0 is ignored.
- R9: Issued stores leave the queue at the clock edge. Their slots become free and `alloc_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Request to append a store |
| alloc_addr | input | ADDR_W | Physical address of the new store |
| alloc_tag | input | TAG_W | Identifier of the new store |
| alloc_ready | output | 1 | A free slot exists |
| alloc_slot | output | log2(DEPTH) | Slot the next allocation will take |
| commit_valid | input | 1 | Commit strobe |
| commit_slot | input | log2(DEPTH) | Slot being committed |
| issue_budget | input | log2(LANES+1) | Maximum stores to issue this cycle |
| probe_addr | output | LANES x ADDR_W | Addresses of the oldest entries, lane 0 oldest |
| cache_ok | input | LANES | Cache accepts the lane's address |
| iss_valid | output | LANES | Lane issues a store this cycle |
| iss_tag | output | LANES x TAG_W | Tag of each lane's store |
| iss_stamp | output | CYC_W | Cycle number stamped on issued stores |
| done_valid | input | 1 | Cache reports one store completion |
| pend_count | output | PEND_W | Issued stores awaiting completion |

## Verification
The drain logic is tried with four patterns. In the first, the head is uncommitted while younger stores behind it are committed, which separates in-order stopping from a bypass. In the second, the head and a middle lane are refused by the cache, which shows that a refusal cuts the run at that lane. The third limits the run with the budget at 0 and at 1. The fourth uses a fully committed full queue that drains four at a time, which tests lane ordering and the wrap of the pointers. Completions are sent with the pending count at zero and also in the same cycle as an issue, to separate ignoring them from decrementing.

// File: rtl/sdq_pkg.sv
// Package: shared widths and types for the committed store drain queue.
// Assumes address and tag widths are fixed per chip and shared with the cache.
package sdq_pkg;
    localparam int SDQ_ADDR_W = 32;
    localparam int SDQ_TAG_W  = 8;

    typedef logic [SDQ_ADDR_W-1:0] sdq_addr_t;
    typedef logic [SDQ_TAG_W-1:0]  sdq_tag_t;
endpackage

// File: rtl/sdq_ring.sv
// Module: circular store buffer with per-slot commit flags.
// Holds stores in program order between head and tail. It exposes the LANES
// oldest entries and removes pop_n of them at the clock edge.
// Assumes pop_n never exceeds the number of live entries (the selector ensures it).
module sdq_ring
    import sdq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LANES = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int BUD_W = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_valid,
    input  sdq_addr_t              alloc_addr,
    input  sdq_tag_t               alloc_tag,
    output logic                   alloc_ready,
    output logic [IDX_W-1:0]       alloc_slot,
    input  logic                   commit_valid,
    input  logic [IDX_W-1:0]       commit_slot,
    input  logic [BUD_W-1:0]       pop_n,
    output logic [LANES-1:0]       cand_live,
    output logic [LANES-1:0]       cand_comm,
    output sdq_addr_t [LANES-1:0]  cand_addr,
    output sdq_tag_t  [LANES-1:0]  cand_tag
);
    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;
    logic [DEPTH-1:0] valid_q, comm_q;
    sdq_addr_t        addr_q [DEPTH];
    sdq_tag_t         tag_q  [DEPTH];
    logic             do_alloc;

    // Ring index addition with wrap at DEPTH.
    function automatic logic [IDX_W-1:0] ring_add(input logic [IDX_W-1:0] base, input int unsigned off);
        int unsigned s;
        s = (int'(base) + off) % DEPTH;
        return IDX_W'(s);
    endfunction

    // Allocation is accepted only when a slot is free.
    always_comb begin
        alloc_ready = (count_q < CNT_W'(DEPTH));
        alloc_slot  = tail_q;
        do_alloc    = alloc_valid && alloc_ready;
    end

    // Present the LANES oldest entries, lane 0 being the head.
    for (genvar k = 0; k < LANES; k++) begin : g_cand
        logic [IDX_W-1:0] slot_k;
        assign slot_k       = ring_add(head_q, k);
        assign cand_live[k] = (CNT_W'(k) < count_q);
        assign cand_comm[k] = comm_q[slot_k];
        assign cand_addr[k] = addr_q[slot_k];
        assign cand_tag[k]  = tag_q[slot_k];
    end

    // Pointer, occupancy and flag update: commit first, pop clears, alloc writes last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            valid_q <= '0;
            comm_q  <= '0;
        end else begin
            if (commit_valid && valid_q[commit_slot]) begin
                comm_q[commit_slot] <= 1'b1;
            end
            for (int k = 0; k < LANES; k++) begin
                if (BUD_W'(k) < pop_n) begin
                    valid_q[ring_add(head_q, k)] <= 1'b0;
                    comm_q[ring_add(head_q, k)]  <= 1'b0;
                end
            end
            if (do_alloc) begin
                valid_q[tail_q] <= 1'b1;
                comm_q[tail_q]  <= 1'b0;
                tail_q          <= ring_add(tail_q, 1);
            end
            head_q  <= ring_add(head_q, int'(pop_n));
            count_q <= count_q + CNT_W'(do_alloc) - CNT_W'(pop_n);
        end
    end

    // Payload capture; data needs no reset.
    always_ff @(posedge clk) begin
        if (do_alloc) begin
            addr_q[tail_q] <= alloc_addr;
            tag_q[tail_q]  <= alloc_tag;
        end
    end

    AST_RING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH)); // R2
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_W'(DEPTH) && pop_n == '0) |=> count_q == CNT_W'(DEPTH)); // R2
    AST_POP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(pop_n) <= count_q); // R9
endmodule

// File: rtl/sdq_drain_sel.sv
// Module: in-order drain selector.
// Grants lane k only if every older lane is granted, the entry is live,
// committed and accepted by the cache, and the budget exceeds k.
// Assumes lane 0 is the oldest entry.
module sdq_drain_sel #(
    parameter int LANES = 4,
    localparam int BUD_W = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] live,
    input  logic [LANES-1:0] comm,
    input  logic [LANES-1:0] ok,
    input  logic [BUD_W-1:0] budget,
    output logic [LANES-1:0] go,
    output logic [BUD_W-1:0] go_n
);
    // Grant chain: a lane may go only behind a granted older lane.
    for (genvar k = 0; k < LANES; k++) begin : g_chain
        logic lane_fit;
        assign lane_fit = live[k] && comm[k] && ok[k] && (budget > BUD_W'(k));
        if (k == 0) begin : g_first
            assign go[k] = lane_fit;
        end else begin : g_rest
            assign go[k] = lane_fit && go[k-1];
        end
    end

    // Count of granted lanes, used to pop the ring and bump the pending count.
    always_comb begin
        go_n = '0;
        for (int k = 0; k < LANES; k++) begin
            go_n = go_n + BUD_W'(go[k]);
        end
    end

    AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(go) <= int'(budget)); // R5
    for (genvar k = 0; k < LANES; k++) begin : g_chk
        AST_COMMITTED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            go[k] |-> (comm[k] && live[k])); // R3
        AST_CACHE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
            go[k] |-> ok[k]); // R4
        if (k > 0) begin : g_run
            AST_LANE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
                go[k] |-> go[k-1]); // R6
        end
    end
endmodule

// File: rtl/sdq_pending.sv
// Module: cycle counter and issued-but-incomplete store counter.
// Assumes PEND_W is wide enough for every store that can be in flight at once.
module sdq_pending #(
    parameter int LANES  = 4,
    parameter int PEND_W = 6,
    parameter int CYC_W  = 16,
    localparam int BUD_W = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUD_W-1:0]  issued_n,
    input  logic              done_valid,
    output logic [PEND_W-1:0] pend_count,
    output logic [CYC_W-1:0]  cyc_now
);
    logic [PEND_W-1:0] pend_q;
    logic [CYC_W-1:0]  cyc_q;
    logic              take_done;

    // A completion counts only when something is already outstanding.
    assign take_done = done_valid && (pend_q != '0);

    // Free-running cycle number, zero in the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_q + CYC_W'(1);
    end

    // Outstanding store count.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_q + PEND_W'(issued_n) - PEND_W'(take_done);
    end

    assign pend_count = pend_q;
    assign cyc_now    = cyc_q;

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cyc_q == CYC_W'($past(cyc_q) + CYC_W'(1))); // R7
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && pend_q == '0 && issued_n == '0) |=> pend_q == '0); // R8
    AST_PEND_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        !done_valid |=> pend_q == PEND_W'($past(pend_q) + PEND_W'($past(issued_n)))); // R8
endmodule

// File: rtl/store_drain_queue.sv
// Module: committed store drain queue, top level.
// Ties the ring, the in-order selector and the pending counter together.
// The cache sees probe_addr and answers with cache_ok in the same cycle.
// Issued lanes leave at the following clock edge.
module store_drain_queue
    import sdq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int LANES  = 4,
    parameter int PEND_W = 6,
    parameter int CYC_W  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int BUD_W = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_valid,
    input  sdq_addr_t             alloc_addr,
    input  sdq_tag_t              alloc_tag,
    output logic                  alloc_ready,
    output logic [IDX_W-1:0]      alloc_slot,
    input  logic                  commit_valid,
    input  logic [IDX_W-1:0]      commit_slot,
    input  logic [BUD_W-1:0]      issue_budget,
    output sdq_addr_t [LANES-1:0] probe_addr,
    input  logic [LANES-1:0]      cache_ok,
    output logic [LANES-1:0]      iss_valid,
    output sdq_tag_t  [LANES-1:0] iss_tag,
    output logic [CYC_W-1:0]      iss_stamp,
    input  logic                  done_valid,
    output logic [PEND_W-1:0]     pend_count
);
    logic [LANES-1:0] cand_live, cand_comm;
    logic [BUD_W-1:0] go_n;

    sdq_ring #(.DEPTH(DEPTH), .LANES(LANES)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_tag(alloc_tag),
        .alloc_ready(alloc_ready), .alloc_slot(alloc_slot),
        .commit_valid(commit_valid), .commit_slot(commit_slot),
        .pop_n(go_n),
        .cand_live(cand_live), .cand_comm(cand_comm),
        .cand_addr(probe_addr), .cand_tag(iss_tag)
    );

    sdq_drain_sel #(.LANES(LANES)) u_sel (
        .clk(clk), .rst_n(rst_n),
        .live(cand_live), .comm(cand_comm), .ok(cache_ok),
        .budget(issue_budget), .go(iss_valid), .go_n(go_n)
    );

    sdq_pending #(.LANES(LANES), .PEND_W(PEND_W), .CYC_W(CYC_W)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .issued_n(go_n), .done_valid(done_valid),
        .pend_count(pend_count), .cyc_now(iss_stamp)
    );

    AST_NO_ISSUE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_live[0] |-> iss_valid == '0); // R9
    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready && go_n == '0) |=> !alloc_ready); // R2
endmodule

// File: tb/sim_store_drain_queue.sv
module sim_store_drain_queue;
    localparam int DEPTH = 8;
    localparam int LANES = 4;

    typedef struct packed {
        logic       av;
        logic [7:0] aaddr;
        logic       cv;
        logic [2:0] cs;
        logic [2:0] bud;
        logic [3:0] ok;
        logic       dn;
        logic [3:0] e_mask;
        logic       e_rdy;
        logic [2:0] e_slot;
        logic [5:0] e_pend;
        logic [7:0] e_a0;
    } vec_t;

    // Stimulus and expected outputs per cycle after reset (see brief for R tags).
    localparam vec_t VECS [14] = '{
        '{1'b1, 8'h10, 1'b0, 3'd0, 3'd4, 4'hF, 1'b0, 4'h0, 1'b1, 3'd0, 6'd0, 8'h00}, // R2 empty
        '{1'b1, 8'h11, 1'b1, 3'd0, 3'd4, 4'hF, 1'b0, 4'h0, 1'b1, 3'd1, 6'd0, 8'h00}, // R3 uncommitted
        '{1'b1, 8'h12, 1'b1, 3'd2, 3'd0, 4'hF, 1'b0, 4'h0, 1'b1, 3'd2, 6'd0, 8'h00}, // R5 budget 0, R3 stray commit
        '{1'b1, 8'h13, 1'b1, 3'd1, 3'd4, 4'h0, 1'b0, 4'h0, 1'b1, 3'd3, 6'd0, 8'h00}, // R4 head refused
        '{1'b0, 8'h00, 1'b1, 3'd3, 3'd4, 4'hF, 1'b0, 4'h3, 1'b1, 3'd4, 6'd0, 8'h10}, // R3 run stops at slot2
        '{1'b0, 8'h00, 1'b1, 3'd2, 3'd4, 4'hF, 1'b1, 4'h0, 1'b1, 3'd4, 6'd2, 8'h00}, // R3 no bypass of head
        '{1'b0, 8'h00, 1'b0, 3'd0, 3'd1, 4'hF, 1'b0, 4'h1, 1'b1, 3'd4, 6'd1, 8'h12}, // R5 budget 1
        '{1'b0, 8'h00, 1'b0, 3'd0, 3'd4, 4'hF, 1'b1, 4'h1, 1'b1, 3'd4, 6'd2, 8'h13}, // R8 issue+done
        '{1'b1, 8'h14, 1'b0, 3'd0, 3'd4, 4'hF, 1'b1, 4'h0, 1'b1, 3'd4, 6'd2, 8'h00}, // R8
        '{1'b1, 8'h15, 1'b1, 3'd4, 3'd4, 4'hF, 1'b1, 4'h0, 1'b1, 3'd5, 6'd1, 8'h00}, // R8
        '{1'b1, 8'h16, 1'b1, 3'd5, 3'd4, 4'hF, 1'b1, 4'h1, 1'b1, 3'd6, 6'd0, 8'h14}, // R8 done at zero
        '{1'b1, 8'h17, 1'b1, 3'd6, 3'd4, 4'hD, 1'b0, 4'h1, 1'b1, 3'd7, 6'd1, 8'h15}, // R4 lane1 refused
        '{1'b0, 8'h00, 1'b1, 3'd7, 3'd4, 4'hF, 1'b0, 4'h1, 1'b1, 3'd0, 6'd2, 8'h16}, // R2 tail wrap
        '{1'b0, 8'h00, 1'b0, 3'd0, 3'd4, 4'hF, 1'b0, 4'h1, 1'b1, 3'd0, 6'd3, 8'h17}  // R6 head wrap
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0;
    logic [31:0] alloc_addr = '0;
    logic [7:0] alloc_tag = '0;
    logic alloc_ready;
    logic [2:0] alloc_slot;
    logic commit_valid = 1'b0;
    logic [2:0] commit_slot = '0;
    logic [2:0] issue_budget = '0;
    logic [LANES-1:0][31:0] probe_addr;
    logic [LANES-1:0] cache_ok = '0;
    logic [LANES-1:0] iss_valid;
    logic [LANES-1:0][7:0] iss_tag;
    logic [15:0] iss_stamp;
    logic done_valid = 1'b0;
    logic [5:0] pend_count;

    int checks = 0;
    int errors = 0;
    int edges_since_reset = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    // Independent count of clock edges since reset release (R7).
    always @(posedge clk) begin
        if (!rst_n) edges_since_reset <= 0;
        else        edges_since_reset <= edges_since_reset + 1;
    end

    store_drain_queue #(.DEPTH(DEPTH), .LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_tag(alloc_tag),
        .alloc_ready(alloc_ready), .alloc_slot(alloc_slot),
        .commit_valid(commit_valid), .commit_slot(commit_slot),
        .issue_budget(issue_budget), .probe_addr(probe_addr), .cache_ok(cache_ok),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_stamp(iss_stamp),
        .done_valid(done_valid), .pend_count(pend_count)
    );

    task automatic chk(input bit good, input string req, input longint act, input longint exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alloc_valid = 1'b0; commit_valid = 1'b0; done_valid = 1'b0;
        issue_budget = 3'd0; cache_ok = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(alloc_ready == 1'b1, "R1 alloc_ready", alloc_ready, 1);
        chk(alloc_slot == 3'd0, "R1 alloc_slot", alloc_slot, 0);
        chk(pend_count == 6'd0, "R1 pend_count", pend_count, 0);
        issue_budget = 3'd4; cache_ok = 4'hF; #1;
        chk(iss_valid == 4'h0, "R1 iss_valid", iss_valid, 0);
    endtask

    initial begin
        do_reset();
        // Vector walk.
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            alloc_valid  = VECS[i].av;
            alloc_addr   = {24'h0, VECS[i].aaddr};
            alloc_tag    = VECS[i].aaddr ^ 8'h5A;
            commit_valid = VECS[i].cv;
            commit_slot  = VECS[i].cs;
            issue_budget = VECS[i].bud;
            cache_ok     = VECS[i].ok;
            done_valid   = VECS[i].dn;
            #2;
            chk(iss_valid == VECS[i].e_mask, "R3/R4/R5 iss_valid", iss_valid, VECS[i].e_mask);
            chk(alloc_ready == VECS[i].e_rdy, "R2 alloc_ready", alloc_ready, VECS[i].e_rdy);
            chk(alloc_slot == VECS[i].e_slot, "R2 alloc_slot", alloc_slot, VECS[i].e_slot);
            chk(pend_count == VECS[i].e_pend, "R8 pend_count", pend_count, VECS[i].e_pend);
            if (VECS[i].e_mask != 4'h0) begin
                chk(probe_addr[0] == {24'h0, VECS[i].e_a0}, "R6 lane0 addr", probe_addr[0], VECS[i].e_a0);
                chk(iss_stamp == 16'(edges_since_reset), "R7 iss_stamp", iss_stamp, edges_since_reset);
            end
        end

        // Directed: fill to full, refuse overflow, drain four at a time.
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            idle_inputs();
            alloc_valid = 1'b1;
            alloc_addr  = 32'h20 + 32'(i);
            alloc_tag   = 8'h20 + 8'(i);
        end
        @(negedge clk);
        idle_inputs();
        alloc_valid = 1'b1; alloc_addr = 32'h99; alloc_tag = 8'h99;
        #2;
        chk(alloc_ready == 1'b0, "R2 full refuses", alloc_ready, 0);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            idle_inputs();
            commit_valid = 1'b1;
            commit_slot  = 3'(i);
        end
        @(negedge clk);
        idle_inputs();
        issue_budget = 3'd4; cache_ok = 4'hF;
        #2;
        chk(iss_valid == 4'hF, "R6 full drain lanes", iss_valid, 4'hF);
        for (int k = 0; k < LANES; k++) begin
            chk(probe_addr[k] == 32'h20 + 32'(k), "R6 lane order", probe_addr[k], 32'h20 + k);
        end
        chk(iss_tag[1] == 8'h21, "R6 lane tag", iss_tag[1], 8'h21);
        @(negedge clk);
        #2;
        chk(alloc_ready == 1'b1, "R9 slots freed", alloc_ready, 1);
        chk(iss_valid == 4'hF, "R6 second drain", iss_valid, 4'hF);
        chk(probe_addr[3] == 32'h27, "R6 lane3 addr", probe_addr[3], 32'h27);
        chk(pend_count == 6'd4, "R8 pending after 4", pend_count, 4);
        @(negedge clk);
        #2;
        chk(iss_valid == 4'h0, "R2 overflow store dropped", iss_valid, 0);
        chk(pend_count == 6'd8, "R8 pending after 8", pend_count, 8);
        idle_inputs();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule